// File: doc/BRIEF.md
# Stall Timer and Delayed Interrupt Generator

This is a validation helper peripheral for processor test benches on silicon or in emulation. It keeps sixteen 32-bit general registers and a free-running 32-bit cycle counter. A host writes and reads the registers through a simple register port. It then issues short commands, each made of a 4-bit opcode and a 4-bit register index, to get one of these effects: stall for a programmed number of cycles, raise an active-low fast or normal interrupt line after a programmed delay, drop either line again, or capture the cycle counter.

Every command that is accepted answers one cycle after its strobe. The answer is a response code on a valid strobe. A timed stall keeps reporting busy each cycle until its delay has elapsed, then reports done once. Each interrupt line has a single countdown, and a new schedule on the same line replaces the one already running.

Top module: `stall_irq_gen`

## Requirements
- R1: A register write (`reg_wr` high at a clock edge) stores `reg_wdata` into the register selected by `reg_idx`. `reg_rdata` always shows the register selected by `reg_idx`. All sixteen registers are zero after reset.
- R2: `cycle_count` is zero after reset, increases by one every clock cycle, and wraps modulo 2^32.
- R3: A command strobe that is accepted is answered on the next cycle with `rsp_valid` high and `rsp_code` set: 2'b00 means done, 2'b01 means busy, 2'b10 means cannot execute. When no command is accepted and no stall is running, `rsp_valid` is low.
- R4: Opcode 0 (stall) with a zero value in the indexed register answers done at once.
- R5: Opcode 0 with a value d>0 in the indexed register answers busy for d consecutive cycles and then done for one cycle. The elapsed time is measured with wrap-safe subtraction on the cycle counter. A command strobe that arrives while a stall is running is ignored: it gets no response and has no effect.
- R6: Opcode 1 answers done. It drives `fiq_n` low d cycles after the cycle in which its response appears, where d is the value in the indexed register. With d=0, `fiq_n` goes low in the response cycle itself.
- R7: Opcode 2 does the same as opcode 1, but for `irq_n`.
- R8: A second schedule command on a line while its countdown is running restarts the countdown from the new delay.
- R9: Opcode 3 answers done, drives `fiq_n` high and cancels any pending `fiq_n` countdown. Opcode 4 does the same for `irq_n`.
- R10: Opcode 5 answers done and stores into the indexed register the `cycle_count` value seen in the strobe cycle. If a port write targets the same register in the same cycle, the captured count wins.
- R11: Opcodes 6 to 15 answer cannot execute. They change no register and neither interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_idx | input | 4 | Register holding the delay, or receiving the captured count |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 done, 01 busy, 10 cannot execute |
| cycle_count | output | 32 | Free-running cycle counter |
| fiq_n | output | 1 | Active-low fast interrupt |
| irq_n | output | 1 | Active-low normal interrupt |

## Verification
A count-capture command and a port write can both target one register in the same cycle. The bench provokes this by raising both strobes at the same negative edge with the same index. It then reads the register back through `reg_rdata` and expects the counter value from the strobe cycle, not the written data. A second collision places a clear command two cycles before a pending countdown would expire. The line must stay high past the old expiry cycle.

// File: rtl/stall_irq_gen.sv
module stall_irq_gen #(
  parameter int W    = 32,
  parameter int NREG = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [3:0]   reg_idx,
  input  logic [31:0]  reg_wdata,
  output logic [31:0]  reg_rdata,
  input  logic         cmd_valid,
  input  logic [3:0]   cmd_op,
  input  logic [3:0]   cmd_idx,
  output logic         rsp_valid,
  output logic [1:0]   rsp_code,
  output logic [31:0]  cycle_count,
  output logic         fiq_n,
  output logic         irq_n
);
  localparam logic [1:0] RSP_DONE = 2'b00;
  localparam logic [1:0] RSP_BUSY = 2'b01;
  localparam logic [1:0] RSP_CANT = 2'b10;

  logic [W-1:0] bank [NREG];
  logic [W-1:0] cnt, t0, wait_len;
  logic         stalling;

  wire          accept = cmd_valid && !stalling;
  wire [W-1:0]  dly    = bank[cmd_idx];

  assign reg_rdata   = bank[reg_idx];
  assign cycle_count = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else begin
      if (reg_wr) bank[reg_idx] <= reg_wdata;
      if (accept && cmd_op == 4'd5) bank[cmd_idx] <= cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RSP_DONE;
      stalling  <= 1'b0;
      t0        <= '0;
      wait_len  <= '0;
    end else if (stalling) begin
      rsp_valid <= 1'b1;
      if (cnt - t0 >= wait_len) begin
        rsp_code <= RSP_DONE;
        stalling <= 1'b0;
      end else begin
        rsp_code <= RSP_BUSY;
      end
    end else if (cmd_valid) begin
      rsp_valid <= 1'b1;
      rsp_code  <= RSP_DONE;
      if (cmd_op == 4'd0 && dly != '0) begin
        rsp_code <= RSP_BUSY;
        stalling <= 1'b1;
        t0       <= cnt;
        wait_len <= dly;
      end else if (cmd_op > 4'd5) begin
        rsp_code <= RSP_CANT;
      end
    end else begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_line
    logic         line_n, armed;
    logic [W-1:0] left;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_n <= 1'b1;
        armed  <= 1'b0;
        left   <= '0;
      end else if (accept && cmd_op == 4'(3 + ch)) begin
        line_n <= 1'b1;
        armed  <= 1'b0;
      end else if (accept && cmd_op == 4'(1 + ch)) begin
        if (dly == '0) begin
          line_n <= 1'b0;
          armed  <= 1'b0;
        end else begin
          armed <= 1'b1;
          left  <= dly;
        end
      end else if (armed) begin
        if (left == W'(1)) begin
          line_n <= 1'b0;
          armed  <= 1'b0;
        end else begin
          left <= left - 1'b1;
        end
      end
    end
  end

  assign fiq_n = g_line[0].line_n;
  assign irq_n = g_line[1].line_n;
endmodule

// File: rtl/stall_irq_gen_chk.sv
module stall_irq_gen_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmd_valid,
  input logic [3:0]   cmd_op,
  input logic         stalling,
  input logic [W-1:0] dly,
  input logic         rsp_valid,
  input logic [1:0]   rsp_code,
  input logic [31:0]  cycle_count,
  input logic         fiq_n,
  input logic         irq_n
);
  wire acc = cmd_valid && !stalling;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cycle_count == $past(cycle_count) + 32'd1);
  p_answer_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_zero_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd0 && dly == '0 |=> rsp_code == 2'b00);
  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code == 2'b01 |=> rsp_valid);
  p_fiq_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd1 && dly == '0 |=> !fiq_n);
  p_irq_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd2 && dly == '0 |=> !irq_n);
  p_fiq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd3 |=> fiq_n);
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd4 |=> irq_n);
  p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op > 4'd5 |=> rsp_code == 2'b10);
endmodule

bind stall_irq_gen stall_irq_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .stalling(stalling), .dly(dly), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
  .cycle_count(cycle_count), .fiq_n(fiq_n), .irq_n(irq_n)
);

// File: tb/stall_irq_gen_bench.sv
module stall_irq_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, cmd_valid = 1'b0;
  logic [3:0] reg_idx = '0, cmd_op = '0, cmd_idx = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, cycle_count;
  logic rsp_valid, fiq_n, irq_n;
  logic [1:0] rsp_code;

  always #4 clk = ~clk;

  stall_irq_gen u_stall_irq_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .cycle_count(cycle_count), .fiq_n(fiq_n), .irq_n(irq_n)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [1:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] code, input string tag);
    exp_q.push_back(code);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [3:0] op, input logic [3:0] idx);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected response", {30'd0, rsp_code}, 32'hx);
      else begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_code == e, t, {30'd0, rsp_code}, {30'd0, e});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 0, "R1 reset register", reg_rdata, 0);
    chk(fiq_n && irq_n, "R6 R7 lines high after reset", {fiq_n, irq_n}, 2'b11);
    chk(!rsp_valid, "R3 idle no response", rsp_valid, 0);
    a = cycle_count;
    chk(a <= 32'd2, "R2 counter near zero after reset", a, 1);
    repeat (5) @(negedge clk);
    chk(cycle_count == a + 5, "R2 counter step", cycle_count, a + 5);

    wr(4'd2, 32'h1234_5678);
    wr(4'd9, 32'hA5A5_0F0F);
    @(negedge clk); reg_idx = 4'd2; #1;
    chk(reg_rdata == 32'h1234_5678, "R1 readback r2", reg_rdata, 32'h1234_5678);
    reg_idx = 4'd9; #1;
    chk(reg_rdata == 32'hA5A5_0F0F, "R1 readback r9", reg_rdata, 32'hA5A5_0F0F);

    push(2'b00, "R4 zero stall");
    send(4'd0, 4'd0);

    wr(4'd1, 32'd3);
    repeat (3) push(2'b01, "R5 busy");
    push(2'b00, "R5 stall done");
    send(4'd0, 4'd1);
    send(4'd1, 4'd0);
    repeat (4) @(negedge clk);
    chk(fiq_n, "R5 command during stall ignored", fiq_n, 1);

    wr(4'd4, 32'd4);
    push(2'b00, "R6 schedule");
    send(4'd1, 4'd4);
    repeat (4) @(negedge clk);
    chk(fiq_n, "R6 fiq high before delay", fiq_n, 1);
    @(negedge clk);
    chk(!fiq_n, "R6 fiq low after delay", fiq_n, 0);
    push(2'b00, "R9 clear");
    send(4'd3, 4'd0);
    @(negedge clk);
    chk(fiq_n, "R9 fiq cleared", fiq_n, 1);

    push(2'b00, "R6 immediate");
    send(4'd1, 4'd0);
    @(negedge clk);
    chk(!fiq_n, "R6 zero delay fiq", fiq_n, 0);
    push(2'b00, "R9 clear");
    send(4'd3, 4'd0);

    push(2'b00, "R9 schedule");
    send(4'd1, 4'd4);
    @(negedge clk);
    push(2'b00, "R9 cancel");
    send(4'd3, 4'd0);
    repeat (5) @(negedge clk);
    chk(fiq_n, "R9 countdown cancelled", fiq_n, 1);

    push(2'b00, "R7 immediate");
    send(4'd2, 4'd0);
    @(negedge clk);
    chk(!irq_n, "R7 zero delay irq", irq_n, 0);
    push(2'b00, "R9 irq clear");
    send(4'd4, 4'd0);
    @(negedge clk);
    chk(irq_n, "R9 irq cleared", irq_n, 1);

    push(2'b00, "R8 first");
    send(4'd2, 4'd4);
    push(2'b00, "R8 second");
    send(4'd2, 4'd4);
    repeat (4) @(negedge clk);
    chk(irq_n, "R8 old expiry suppressed", irq_n, 1);
    @(negedge clk);
    chk(!irq_n, "R8 restarted expiry", irq_n, 0);
    push(2'b00, "R9 irq clear");
    send(4'd4, 4'd0);

    @(negedge clk);
    snap = cycle_count;
    cmd_valid = 1'b1; cmd_op = 4'd5; cmd_idx = 4'd7;
    reg_wr = 1'b1; reg_idx = 4'd7; reg_wdata = 32'hDEAD_BEEF;
    push(2'b00, "R10 capture");
    @(posedge clk); #1;
    cmd_valid = 1'b0; reg_wr = 1'b0;
    @(negedge clk);
    chk(reg_rdata == snap, "R10 capture beats write", reg_rdata, snap);
    @(negedge clk);
    snap = cycle_count;
    cmd_valid = 1'b1; cmd_op = 4'd5; cmd_idx = 4'd8;
    push(2'b00, "R10 capture");
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(negedge clk); reg_idx = 4'd8; #1;
    chk(reg_rdata == snap, "R10 plain capture", reg_rdata, snap);

    push(2'b10, "R11 op6");
    send(4'd6, 4'd2);
    push(2'b10, "R11 op15");
    send(4'd15, 4'd2);
    @(negedge clk); reg_idx = 4'd2; #1;
    chk(reg_rdata == 32'h1234_5678, "R11 register untouched", reg_rdata, 32'h1234_5678);
    chk(fiq_n && irq_n, "R11 lines untouched", {fiq_n, irq_n}, 2'b11);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all responses seen", exp_q.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule